// File: doc/BRIEF.md
# ATAPI Device Task-File Controller

This block is the device side of an ATAPI-style storage port. It holds the task-file registers that the host reads and writes, and it runs the transfer state machine behind them. The host issues a packet command and then writes a 12-byte command packet as six 16-bit data writes. The block hands the assembled packet to a downstream decoder over a valid/ready pair. It waits in a busy state until the decoder has placed a response in the internal byte buffer and starts a response transfer. The response goes back to the host either as little-endian 16-bit PIO words through the data register, or as a byte stream in answer to DMA length requests.

Every state change writes fixed status, error and count encodings, so host software can follow the protocol from the registers alone. An interrupt-pending flag is set by the protocol events and cleared by a command write or by a status read while the device is not busy. A mask bit in the control register gates the interrupt pin and leaves the flag itself untouched. The abort (NOP) and set-features commands complete inside the block. Packet meaning, the media model and DMA bus timing belong to other blocks.

Top module: `atapi_taskfile`

## Requirements
- R1: After reset: error 0x01, count 0x01, sector byte 0x81, byte-count low 0x14, byte-count high 0xEB, status 0x00, device 0x00, state idle, interrupt low, no packet offered, and the after-reset flag set.
- R2: Writing command 0xA0 (packet) sets status 0x58, count 0x01 (command phase), error = feature[1:0], and expects 12 bytes.
- R3: In the command phase each data write stores one word (low byte at the even packet byte k, high byte at k+1; byte k is pkt_data[8k+7:8k]). The sixth word sets status 0xD0 (DRQ clear, BSY set) and raises pkt_valid, which stays high until pkt_ready.
- R4: pkt_after_reset stays 1 from reset until the first packet handshake, and is 0 after it.
- R5: A PIO response start sets status 0x58, count 0x02 (data-in), error 0x00, byte-count low/high = length[7:0]/length[11:8], and raises the interrupt.
- R6: Each PIO data read returns {byte[ofs+1], byte[ofs]} and advances ofs by 2. The read that reaches the length sets state idle, status 0x50, count 0x03 and raises the interrupt, and it pulses sector_req when more_sectors is 1.
- R7: A data-register read in any state other than PIO read returns 0xFFFF.
- R8: A DMA response start sets status 0xD0 and raises no interrupt. Each nonzero DMA request grants min(request, bytes remaining) bytes, one per cycle on dma_valid/dma_byte, in buffer order.
- R9: When DMA drains the buffer with more_sectors 0, the block sets status 0x50 and count 0x03, raises the interrupt and pulses dma_done together with the last byte. With more_sectors 1 it instead pulses sector_req, stays busy at status 0xD0, and gives no dma_done.
- R10: Command 0x00 (NOP) aborts: state idle, status 0x51, error 0x04, interrupt raised, and no further data.
- R11: Command 0xEF (set features) sets status 0x50, error 0x00 and both byte-count registers to 0x00, and raises the interrupt. When feature is 0x03 it loads xfer_mode from count (bits 7:3 class, bits 2:0 mode); any other feature leaves xfer_mode unchanged.
- R12: Any command write first clears the pending interrupt. An unrecognised opcode has no other effect.
- R13: A status read (select 7) clears the pending flag only when status bit 7 (BSY) is 0. An alternate-status read (select 8) never clears it.
- R14: intrq is the registered value of pending AND NOT mask, where the mask is control bit 1. Writing the mask never changes the pending flag, and clearing it brings intrq back while the flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (side effects at the clock edge) |
| reg_sel | input | 4 | Register select: 0 data, 1 error/feature, 2 count, 3 byte-count low, 4 byte-count high, 5 sector, 6 device, 7 status/command, 8 alt-status/control |
| reg_wdata | input | 16 | Host write data (byte registers use bits 7:0) |
| reg_rdata | output | 16 | Host read data for reg_sel, combinational |
| pkt_valid | output | 1 | Command packet offered to the decoder |
| pkt_ready | input | 1 | Decoder accepts the packet |
| pkt_data | output | 8*PKT_BYTES (96) | Assembled command packet, byte k at bits 8k+7:8k |
| pkt_after_reset | output | 1 | No packet handed over since reset |
| fill_we | input | 1 | Response buffer byte write |
| fill_addr | input | OFS_W (12) | Response buffer byte address |
| fill_data | input | 8 | Response buffer byte |
| rsp_start | input | 1 | Start a response transfer (accepted when idle or busy) |
| rsp_dma | input | 1 | 1 selects DMA, 0 selects PIO |
| rsp_len | input | OFS_W (12) | Response length in bytes (at least 1) |
| more_sectors | input | 1 | Further sectors follow this buffer |
| sector_req | output | 1 | One-cycle request for the next sector |
| dma_req | input | 1 | DMA length request strobe |
| dma_len | input | OFS_W (12) | Requested DMA byte count |
| dma_valid | output | 1 | DMA byte valid |
| dma_byte | output | 8 | DMA byte |
| dma_done | output | 1 | One-cycle DMA completion event |
| intrq | output | 1 | Interrupt request pin |
| xfer_mode | output | 8 | Last transfer-mode setting |

## Verification
The hardest situation to reach from the ports is a pending interrupt while BSY is set. Every command write clears the flag, and a DMA start never raises it. The bench gets there by finishing a PIO response with more_sectors high, which leaves the flag set, and then starting a DMA response, which sets BSY. It then shows that a status read keeps the flag, that toggling the mask only gates the pin, and that an unknown opcode clears it. The PIO and DMA paths are swept over several lengths and request chunk sizes, with the expected bytes computed from the fill pattern.

// File: rtl/atapi_tf_pkg.sv
package atapi_tf_pkg;

    typedef enum logic [2:0] {
        TF_IDLE   = 3'd0,
        TF_CMDPKT = 3'd1,
        TF_PIORD  = 3'd2,
        TF_DMARD  = 3'd3,
        TF_BUSY   = 3'd4
    } tf_state_e;

    // host register selects
    localparam logic [3:0] SEL_DATA = 4'd0;
    localparam logic [3:0] SEL_ERR  = 4'd1;
    localparam logic [3:0] SEL_CNT  = 4'd2;
    localparam logic [3:0] SEL_BCLO = 4'd3;
    localparam logic [3:0] SEL_BCHI = 4'd4;
    localparam logic [3:0] SEL_SECT = 4'd5;
    localparam logic [3:0] SEL_DEV  = 4'd6;
    localparam logic [3:0] SEL_STAT = 4'd7;
    localparam logic [3:0] SEL_CTRL = 4'd8;

    // opcodes and feature codes
    localparam logic [7:0] OP_NOP     = 8'h00;
    localparam logic [7:0] OP_PACKET  = 8'hA0;
    localparam logic [7:0] OP_SETFEAT = 8'hEF;
    localparam logic [7:0] FEAT_XMODE = 8'h03;

    // status encodings
    localparam logic [7:0] STS_XFER  = 8'h58;
    localparam logic [7:0] STS_BUSY  = 8'hD0;
    localparam logic [7:0] STS_READY = 8'h50;
    localparam logic [7:0] STS_FAIL  = 8'h51;
    localparam logic [7:0] STS_BSY   = 8'h80;
    localparam logic [7:0] STS_DRQ   = 8'h08;

    // count (interrupt reason) encodings
    localparam logic [7:0] CNT_CMD  = 8'h01;
    localparam logic [7:0] CNT_IN   = 8'h02;
    localparam logic [7:0] CNT_DONE = 8'h03;

endpackage

// File: rtl/atapi_tf_rspbuf.sv
module atapi_tf_rspbuf #(
    parameter int DEPTH = 2352,
    parameter int AW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rword
);
    localparam logic [AW:0] LIMIT = (AW + 1)'(DEPTH);

    logic [7:0] mem_q [DEPTH];
    logic [AW:0] lo_a, hi_a;

    assign lo_a = {1'b0, raddr};
    assign hi_a = lo_a + 1'b1;

    always_ff @(posedge clk) begin
        if (we && ({1'b0, waddr} < LIMIT)) begin
            mem_q[waddr] <= wdata;
        end
    end

    // little-endian word at the byte offset; bytes past the end read zero
    always_comb begin
        rword = '0;
        if (lo_a < LIMIT) rword[7:0]  = mem_q[lo_a[AW-1:0]];
        if (hi_a < LIMIT) rword[15:8] = mem_q[hi_a[AW-1:0]];
    end
endmodule

// File: rtl/atapi_tf_irq.sv
module atapi_tf_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clr_cmd,
    input  logic clr_stat,
    input  logic mask_wr,
    input  logic mask_in,
    output logic pending,
    output logic masked,
    output logic intrq
);
    typedef struct packed {
        logic pending;
        logic mask;
        logic intrq;
    } irq_t;

    irq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_cmd || clr_stat) s_d.pending = 1'b0;
        if (raise)               s_d.pending = 1'b1;
        if (mask_wr)             s_d.mask    = mask_in;
        s_d.intrq = s_q.pending & ~s_q.mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pending = s_q.pending;
    assign masked  = s_q.mask;
    assign intrq   = s_q.intrq;

    assert_mask_keeps_flag_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !raise && !clr_cmd && !clr_stat) |=> $stable(s_q.pending));

    assert_pin_needs_unmask_R14: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.intrq) |-> ($past(s_q.pending) && !$past(s_q.mask)));
endmodule

// File: rtl/atapi_taskfile.sv
module atapi_taskfile
    import atapi_tf_pkg::*;
#(
    parameter int BUF_BYTES = 2352,
    parameter int PKT_BYTES = 12,
    localparam int OFS_W = $clog2(BUF_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [3:0]             reg_sel,
    input  logic [15:0]            reg_wdata,
    output logic [15:0]            reg_rdata,
    output logic                   pkt_valid,
    input  logic                   pkt_ready,
    output logic [PKT_BYTES*8-1:0] pkt_data,
    output logic                   pkt_after_reset,
    input  logic                   fill_we,
    input  logic [OFS_W-1:0]       fill_addr,
    input  logic [7:0]             fill_data,
    input  logic                   rsp_start,
    input  logic                   rsp_dma,
    input  logic [OFS_W-1:0]       rsp_len,
    input  logic                   more_sectors,
    output logic                   sector_req,
    input  logic                   dma_req,
    input  logic [OFS_W-1:0]       dma_len,
    output logic                   dma_valid,
    output logic [7:0]             dma_byte,
    output logic                   dma_done,
    output logic                   intrq,
    output logic [7:0]             xfer_mode
);
    localparam int              PKT_WORDS = PKT_BYTES / 2;
    localparam logic [OFS_W-1:0] PKT_LEN  = OFS_W'(PKT_BYTES);

    typedef struct packed {
        tf_state_e              state;
        logic [7:0]             status;
        logic [7:0]             error;
        logic [7:0]             count;
        logic [7:0]             feature;
        logic [7:0]             bclo;
        logic [7:0]             bchi;
        logic [7:0]             sect;
        logic [7:0]             device;
        logic [7:0]             xmode;
        logic [OFS_W-1:0]       ofs;
        logic [OFS_W-1:0]       len;
        logic [OFS_W-1:0]       dma_left;
        logic [PKT_BYTES*8-1:0] pkt;
        logic                   pkt_valid;
        logic                   after_reset;
        logic                   dma_valid;
        logic [7:0]             dma_byte;
        logic                   dma_done;
        logic                   sreq;
    } tf_regs_t;

    tf_regs_t s_d, s_q;
    logic [15:0]      rd_word;
    logic             raise_d;
    logic             cmd_wr, stat_rd;
    logic             irq_pending, irq_masked;
    logic [OFS_W-1:0] remain;

    assign cmd_wr  = reg_wr && (reg_sel == SEL_STAT);
    assign stat_rd = reg_rd && (reg_sel == SEL_STAT);
    assign remain  = s_q.len - s_q.ofs;

    atapi_tf_rspbuf #(.DEPTH(BUF_BYTES), .AW(OFS_W)) u_buf (
        .clk   (clk),
        .we    (fill_we),
        .waddr (fill_addr),
        .wdata (fill_data),
        .raddr (s_q.ofs),
        .rword (rd_word)
    );

    atapi_tf_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .raise    (raise_d),
        .clr_cmd  (cmd_wr),
        .clr_stat (stat_rd && !s_q.status[7]),
        .mask_wr  (reg_wr && (reg_sel == SEL_CTRL)),
        .mask_in  (reg_wdata[1]),
        .pending  (irq_pending),
        .masked   (irq_masked),
        .intrq    (intrq)
    );

    always_comb begin
        s_d           = s_q;
        s_d.dma_valid = 1'b0;
        s_d.dma_done  = 1'b0;
        s_d.sreq      = 1'b0;
        raise_d       = 1'b0;

        if (s_q.pkt_valid && pkt_ready) begin
            s_d.pkt_valid   = 1'b0;
            s_d.after_reset = 1'b0;
        end

        // DMA stream: one byte per cycle while a grant is open
        if (s_q.state == TF_DMARD) begin
            if (s_q.dma_left != '0) begin
                s_d.dma_valid = 1'b1;
                s_d.dma_byte  = rd_word[7:0];
                s_d.ofs       = s_q.ofs + 1'b1;
                s_d.dma_left  = s_q.dma_left - 1'b1;
                if (s_q.ofs + 1'b1 == s_q.len) begin
                    s_d.dma_left = '0;
                    if (more_sectors) begin
                        s_d.state = TF_BUSY;
                        s_d.sreq  = 1'b1;
                    end else begin
                        s_d.state    = TF_IDLE;
                        s_d.status   = STS_READY;
                        s_d.count    = CNT_DONE;
                        s_d.dma_done = 1'b1;
                        raise_d      = 1'b1;
                    end
                end
            end else if (dma_req && (dma_len != '0)) begin
                s_d.dma_left = (dma_len < remain) ? dma_len : remain;
            end
        end

        // PIO data read side effect
        if (reg_rd && (reg_sel == SEL_DATA) && (s_q.state == TF_PIORD)) begin
            s_d.ofs = s_q.ofs + OFS_W'(2);
            if (s_q.ofs + OFS_W'(2) >= s_q.len) begin
                s_d.state  = TF_IDLE;
                s_d.status = s_q.status & ~STS_DRQ;
                s_d.count  = CNT_DONE;
                s_d.ofs    = '0;
                raise_d    = 1'b1;
                s_d.sreq   = more_sectors;
            end
        end

        if (reg_wr) begin
            case (reg_sel)
                SEL_ERR:  s_d.feature = reg_wdata[7:0];
                SEL_CNT:  s_d.count   = reg_wdata[7:0];
                SEL_BCLO: s_d.bclo    = reg_wdata[7:0];
                SEL_BCHI: s_d.bchi    = reg_wdata[7:0];
                SEL_SECT: s_d.sect    = reg_wdata[7:0];
                SEL_DEV:  s_d.device  = reg_wdata[7:0];
                SEL_DATA: begin
                    if (s_q.state == TF_CMDPKT) begin
                        for (int w = 0; w < PKT_WORDS; w++) begin
                            if (s_q.ofs == OFS_W'(2 * w)) s_d.pkt[16*w +: 16] = reg_wdata;
                        end
                        s_d.ofs = s_q.ofs + OFS_W'(2);
                        if (s_q.ofs + OFS_W'(2) >= s_q.len) begin
                            s_d.state     = TF_BUSY;
                            s_d.status    = (s_q.status & ~STS_DRQ) | STS_BSY;
                            s_d.ofs       = '0;
                            s_d.pkt_valid = 1'b1;
                        end
                    end
                end
                SEL_STAT: begin
                    case (reg_wdata[7:0])
                        OP_NOP: begin
                            s_d.state     = TF_IDLE;
                            s_d.status    = STS_FAIL;
                            s_d.error     = 8'h04;
                            s_d.ofs       = '0;
                            s_d.dma_left  = '0;
                            s_d.dma_valid = 1'b0;
                            s_d.dma_done  = 1'b0;
                            s_d.sreq      = 1'b0;
                            s_d.pkt_valid = 1'b0;
                            raise_d       = 1'b1;
                        end
                        OP_PACKET: begin
                            s_d.state  = TF_CMDPKT;
                            s_d.status = STS_XFER;
                            s_d.error  = {6'b0, s_q.feature[1:0]};
                            s_d.count  = CNT_CMD;
                            s_d.ofs    = '0;
                            s_d.len    = PKT_LEN;
                        end
                        OP_SETFEAT: begin
                            s_d.status = STS_READY;
                            s_d.error  = 8'h00;
                            s_d.bclo   = 8'h00;
                            s_d.bchi   = 8'h00;
                            if (s_q.feature == FEAT_XMODE) s_d.xmode = s_q.count;
                            raise_d    = 1'b1;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end

        // response start from the decoder side
        if (rsp_start && ((s_q.state == TF_IDLE) || (s_q.state == TF_BUSY))) begin
            s_d.error    = 8'h00;
            s_d.count    = CNT_IN;
            s_d.len      = rsp_len;
            s_d.ofs      = '0;
            s_d.dma_left = '0;
            if (rsp_dma) begin
                s_d.state  = TF_DMARD;
                s_d.status = STS_BUSY;
            end else begin
                s_d.state  = TF_PIORD;
                s_d.status = STS_XFER;
                s_d.bclo   = rsp_len[7:0];
                s_d.bchi   = 8'(rsp_len >> 8);
                raise_d    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q             <= '0;
            s_q.error       <= 8'h01;
            s_q.count       <= 8'h01;
            s_q.sect        <= 8'h81;
            s_q.bclo        <= 8'h14;
            s_q.bchi        <= 8'hEB;
            s_q.after_reset <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_DATA: reg_rdata = (s_q.state == TF_PIORD) ? rd_word : 16'hFFFF;
            SEL_ERR:  reg_rdata = {8'h00, s_q.error};
            SEL_CNT:  reg_rdata = {8'h00, s_q.count};
            SEL_BCLO: reg_rdata = {8'h00, s_q.bclo};
            SEL_BCHI: reg_rdata = {8'h00, s_q.bchi};
            SEL_SECT: reg_rdata = {8'h00, s_q.sect};
            SEL_DEV:  reg_rdata = {8'h00, s_q.device};
            SEL_STAT: reg_rdata = {8'h00, s_q.status};
            SEL_CTRL: reg_rdata = {8'h00, s_q.status};
            default:  reg_rdata = 16'h0000;
        endcase
    end

    assign pkt_valid       = s_q.pkt_valid;
    assign pkt_data        = s_q.pkt;
    assign pkt_after_reset = s_q.after_reset;
    assign sector_req      = s_q.sreq;
    assign dma_valid       = s_q.dma_valid;
    assign dma_byte        = s_q.dma_byte;
    assign dma_done        = s_q.dma_done;
    assign xfer_mode       = s_q.xmode;

    assert_pkt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready && !cmd_wr) |=> pkt_valid);

    assert_dma_grant_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == TF_DMARD) |-> (s_q.dma_left <= remain));

    assert_done_with_last_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |-> dma_valid);

    assert_busy_read_keeps_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && s_q.status[7] && irq_pending && !raise_d) |=> irq_pending);

    assert_pkt_handshake_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready) |=> !pkt_after_reset);

    assert_mask_reg_gates_R14: assert property (@(posedge clk) disable iff (!rst_n)
        irq_masked |=> !intrq);
endmodule

// File: tb/atapi_taskfile_tb_top.sv
module atapi_taskfile_tb_top;
    import atapi_tf_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int OW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        pkt_valid, pkt_ready = 1'b0, pkt_after_reset;
    logic [95:0] pkt_data;
    logic        fill_we = 1'b0;
    logic [OW-1:0] fill_addr = '0;
    logic [7:0]  fill_data = '0;
    logic        rsp_start = 1'b0, rsp_dma = 1'b0, more_sectors = 1'b0;
    logic [OW-1:0] rsp_len = '0;
    logic        sector_req;
    logic        dma_req = 1'b0;
    logic [OW-1:0] dma_len = '0;
    logic        dma_valid, dma_done, intrq;
    logic [7:0]  dma_byte, xfer_mode;

    int total = 0, bad = 0;
    int cap_n = 0, done_n = 0, done_bad = 0, sreq_n = 0;
    logic [7:0] cap [512];

    always #(CLK_PERIOD / 2) clk = ~clk;

    atapi_taskfile dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pkt_valid(pkt_valid),
        .pkt_ready(pkt_ready), .pkt_data(pkt_data), .pkt_after_reset(pkt_after_reset),
        .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
        .rsp_start(rsp_start), .rsp_dma(rsp_dma), .rsp_len(rsp_len),
        .more_sectors(more_sectors), .sector_req(sector_req), .dma_req(dma_req),
        .dma_len(dma_len), .dma_valid(dma_valid), .dma_byte(dma_byte),
        .dma_done(dma_done), .intrq(intrq), .xfer_mode(xfer_mode)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (dma_valid) begin
                cap[cap_n % 512] = dma_byte;
                cap_n = cap_n + 1;
            end
            if (dma_done) done_n = done_n + 1;
            if (dma_done && !dma_valid) done_bad = done_bad + 1;
            if (sector_req) sreq_n = sreq_n + 1;
        end
    end

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] s, input logic [15:0] v);
        @(negedge clk);
        reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [15:0] v);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [3:0] s, output logic [15:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic send_packet();
        wr(SEL_STAT, 16'h00A0);
        for (int w = 0; w < 6; w++) wr(SEL_DATA, 16'(16'h1000 + w * 16'h0203));
        @(negedge clk); pkt_ready = 1'b1;
        @(posedge clk); #1; pkt_ready = 1'b0;
    endtask

    task automatic start_rsp(input int len, input logic dma);
        @(negedge clk);
        rsp_start = 1'b1; rsp_dma = dma; rsp_len = OW'(len);
        @(posedge clk); #1;
        rsp_start = 1'b0;
    endtask

    task automatic req_dma(input int n);
        @(negedge clk);
        dma_req = 1'b1; dma_len = OW'(n);
        @(posedge clk); #1;
        dma_req = 1'b0;
    endtask

    task automatic pio_run(input int len, input logic more);
        logic [15:0] v;
        int words;
        more_sectors = more;
        send_packet();
        start_rsp(len, 1'b0);
        cyc(1);
        chk("R5 intrq after start", 32'(intrq), 1);
        peek(SEL_CTRL, v); chk("R5 status", 32'(v), 32'h58);
        peek(SEL_CNT, v);  chk("R5 count", 32'(v), 32'h02);
        peek(SEL_ERR, v);  chk("R5 error", 32'(v), 32'h00);
        peek(SEL_BCLO, v); chk("R5 bc low", 32'(v), 32'(len & 255));
        peek(SEL_BCHI, v); chk("R5 bc high", 32'(v), 32'(len >> 8));
        rd(SEL_STAT, v); cyc(1);
        chk("R13 status read clears when BSY=0", 32'(intrq), 0);
        words = (len + 1) / 2;
        for (int k = 0; k < words; k++) begin
            rd(SEL_DATA, v);
            chk("R6 pio word", 32'(v), 32'({pat(2 * k + 1), pat(2 * k)}));
        end
        cyc(1);
        chk("R6 intrq at end", 32'(intrq), 1);
        peek(SEL_CTRL, v); chk("R6 status end", 32'(v), 32'h50);
        peek(SEL_CNT, v);  chk("R6 count end", 32'(v), 32'h03);
        peek(SEL_DATA, v); chk("R7 data read idle", 32'(v), 32'hFFFF);
        cyc(1);
        chk("R13 alt-status keeps flag", 32'(intrq), 1);
    endtask

    task automatic dma_run(input int len, input int chunk);
        logic [15:0] v;
        int got, base, g, d0;
        more_sectors = 1'b0;
        send_packet();
        base = cap_n; d0 = done_n;
        start_rsp(len, 1'b1);
        cyc(2);
        chk("R8 no intr on dma start", 32'(intrq), 0);
        peek(SEL_CTRL, v); chk("R8 status dma", 32'(v), 32'hD0);
        got = 0;
        while (got < len) begin
            g = (chunk < len - got) ? chunk : len - got;
            req_dma(chunk);
            cyc(g + 2);
            chk("R8 grant size", 32'(cap_n - base - got), 32'(g));
            got = got + g;
        end
        for (int i = 0; i < len; i++)
            chk("R8 dma byte", 32'(cap[(base + i) % 512]), 32'(pat(i)));
        chk("R9 one dma_done", 32'(done_n - d0), 1);
        chk("R9 done with last byte", 32'(done_bad), 0);
        peek(SEL_CTRL, v); chk("R9 status drained", 32'(v), 32'h50);
        peek(SEL_CNT, v);  chk("R9 count drained", 32'(v), 32'h03);
        cyc(1);
        chk("R9 intrq drained", 32'(intrq), 1);
        rd(SEL_STAT, v);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int s0, d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        peek(SEL_ERR, v);  chk("R1 error", 32'(v), 32'h01);
        peek(SEL_CNT, v);  chk("R1 count", 32'(v), 32'h01);
        peek(SEL_SECT, v); chk("R1 sector", 32'(v), 32'h81);
        peek(SEL_BCLO, v); chk("R1 bc low", 32'(v), 32'h14);
        peek(SEL_BCHI, v); chk("R1 bc high", 32'(v), 32'hEB);
        peek(SEL_STAT, v); chk("R1 status", 32'(v), 32'h00);
        peek(SEL_DEV, v);  chk("R1 device", 32'(v), 32'h00);
        peek(SEL_DATA, v); chk("R1 idle data", 32'(v), 32'hFFFF);
        chk("R1 intrq", 32'(intrq), 0);
        chk("R1 pkt_valid", 32'(pkt_valid), 0);
        chk("R1 after-reset flag", 32'(pkt_after_reset), 1);

        // fill response buffer
        for (int i = 0; i < 320; i++) begin
            @(negedge clk);
            fill_we = 1'b1; fill_addr = OW'(i); fill_data = pat(i);
        end
        @(negedge clk); fill_we = 1'b0;

        // R2 packet entry
        wr(SEL_ERR, 16'h0007);
        wr(SEL_STAT, 16'h00A0);
        peek(SEL_STAT, v); chk("R2 status", 32'(v), 32'h58);
        peek(SEL_CNT, v);  chk("R2 count", 32'(v), 32'h01);
        peek(SEL_ERR, v);  chk("R2 error=feature[1:0]", 32'(v), 32'h03);

        // R3 packet capture
        for (int w = 0; w < 5; w++) wr(SEL_DATA, 16'(16'h1000 + w * 16'h0203));
        chk("R3 no valid before 12 bytes", 32'(pkt_valid), 0);
        peek(SEL_STAT, v); chk("R3 status mid-packet", 32'(v), 32'h58);
        wr(SEL_DATA, 16'(16'h1000 + 5 * 16'h0203));
        chk("R3 pkt_valid", 32'(pkt_valid), 1);
        peek(SEL_STAT, v); chk("R3 status busy", 32'(v), 32'hD0);
        for (int k = 0; k < 12; k++) begin
            logic [15:0] wv;
            wv = 16'(16'h1000 + (k / 2) * 16'h0203);
            chk("R3 packet byte", 32'(pkt_data[8*k +: 8]), 32'((k % 2) ? wv[15:8] : wv[7:0]));
        end
        cyc(3);
        chk("R3 valid held", 32'(pkt_valid), 1);
        chk("R4 flag before handshake", 32'(pkt_after_reset), 1);
        @(negedge clk); pkt_ready = 1'b1;
        @(posedge clk); #1; pkt_ready = 1'b0;
        chk("R3 valid dropped", 32'(pkt_valid), 0);
        chk("R4 flag cleared", 32'(pkt_after_reset), 0);
        wr(SEL_STAT, 16'h0000);   // abort back to idle

        // PIO sweep
        pio_run(1, 1'b0);
        pio_run(2, 1'b0);
        pio_run(3, 1'b0);
        pio_run(13, 1'b0);
        pio_run(40, 1'b0);
        pio_run(300, 1'b0);

        // DMA sweep
        dma_run(5, 1);
        dma_run(8, 3);
        dma_run(20, 7);
        dma_run(16, 16);
        dma_run(9, 20);

        // R9 more sectors: next-sector request instead of done
        more_sectors = 1'b1;
        send_packet();
        s0 = sreq_n; d0 = done_n;
        start_rsp(6, 1'b1);
        req_dma(6);
        cyc(8);
        chk("R9 sector_req on drain", 32'(sreq_n - s0), 1);
        chk("R9 no done with more", 32'(done_n - d0), 0);
        peek(SEL_CTRL, v); chk("R9 stays busy", 32'(v), 32'hD0);
        more_sectors = 1'b0;
        start_rsp(4, 1'b1);
        req_dma(10);
        cyc(7);
        chk("R9 next sector done", 32'(done_n - d0), 1);
        rd(SEL_STAT, v);

        // R6 more sectors on PIO, then pending flag with BSY set
        s0 = sreq_n;
        pio_run(4, 1'b1);
        chk("R6 sector_req", 32'(sreq_n - s0), 1);
        more_sectors = 1'b0;
        start_rsp(4, 1'b1);
        rd(SEL_STAT, v);
        chk("R13 busy status", 32'(v), 32'hD0);
        cyc(2);
        chk("R13 read with BSY keeps flag", 32'(intrq), 1);
        wr(SEL_CTRL, 16'h0002);
        cyc(2);
        chk("R14 mask gates pin", 32'(intrq), 0);
        wr(SEL_CTRL, 16'h0000);
        cyc(2);
        chk("R14 unmask restores pin", 32'(intrq), 1);
        wr(SEL_STAT, 16'h0055);
        cyc(2);
        chk("R12 command write clears", 32'(intrq), 0);
        peek(SEL_CTRL, v); chk("R12 unknown opcode no effect", 32'(v), 32'hD0);
        d0 = done_n;
        req_dma(4);
        cyc(7);
        chk("R9 finish", 32'(done_n - d0), 1);
        rd(SEL_STAT, v);

        // R10 abort during PIO
        send_packet();
        start_rsp(10, 1'b0);
        rd(SEL_DATA, v);
        wr(SEL_STAT, 16'h0000);
        peek(SEL_STAT, v); chk("R10 status", 32'(v), 32'h51);
        peek(SEL_ERR, v);  chk("R10 error", 32'(v), 32'h04);
        peek(SEL_DATA, v); chk("R10 no more data", 32'(v), 32'hFFFF);
        cyc(1);
        chk("R10 intrq", 32'(intrq), 1);

        // R11 set features
        wr(SEL_ERR, 16'h0003);
        wr(SEL_CNT, 16'h000C);
        wr(SEL_BCLO, 16'h0077);
        wr(SEL_STAT, 16'h00EF);
        peek(SEL_STAT, v); chk("R11 status", 32'(v), 32'h50);
        peek(SEL_ERR, v);  chk("R11 error", 32'(v), 32'h00);
        peek(SEL_BCLO, v); chk("R11 bc low", 32'(v), 32'h00);
        peek(SEL_BCHI, v); chk("R11 bc high", 32'(v), 32'h00);
        chk("R11 xfer_mode", 32'(xfer_mode), 32'h0C);
        cyc(1);
        chk("R11 intrq", 32'(intrq), 1);
        wr(SEL_ERR, 16'h0002);
        wr(SEL_CNT, 16'h0022);
        wr(SEL_STAT, 16'h00EF);
        chk("R11 other feature keeps mode", 32'(xfer_mode), 32'h0C);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule